// File: doc/BRIEF.md
# Three-Leg Dead-Time Guard with Pulse Filtering

This block sits between a PWM generator and the gate drivers of a three-phase voltage source converter. For each leg it takes a top-device command and a bottom-device command. The two commands are independent, not a signal and its complement. From them it produces two gate outputs that are never high together. Before either device turns on, both gates of that leg stay low for a programmed number of clock cycles, so a device that is slow to turn off cannot short the DC bus. The interval is counted from the clock, so it does not drift the way analog delays do.

Each leg first filters its command pair. A new command level is accepted only after it has held for a programmed minimum number of cycles. Shorter pulses and notches are dropped, and the outputs keep their previous state. A leg state machine then acts on the accepted command. An accepted request for both devices at once is illegal. It forces both gates low, sets a sticky per-leg fault flag, and holds the leg blocked until both commands have been low for one dead-time interval. The dead-time and minimum-width settings are captured only while a leg is idle, so a change made during switching applies once that leg returns to idle. All pins are plain control and status pins with no flow control: commands are levels, and nothing at the block's edge can stall.

Top module: `deadtime_guard`

## Requirements
- R1: While reset is high and in the cycle after it, every gate output and every fault flag is low. Each leg restarts idle with both gates off.
- R2: For any leg, the top gate and the bottom gate are never high in the same cycle.
- R3: A rising edge on any gate follows at least max(1, D) consecutive cycles with both gates of that leg low. D is the dead-time setting held by that leg.
- R4: Accepted commands are encoded {top,bottom}: 2'b10 turns on the top gate, 2'b01 turns on the bottom gate and 2'b00 turns both off. Turn-off is immediate. Turn-on waits for the dead interval. A direct top-to-bottom change passes through the dead interval.
- R5: A command level that holds for fewer than M consecutive cycles does not change the outputs. M is the minimum-width setting held by the leg, and M of 0 behaves as 1. A level that holds for M cycles is accepted.
- R6: An accepted command of 2'b11 drives both gates of that leg low at once and sets that leg's fault flag.
- R7: A blocked leg returns to idle only after its accepted command has been 2'b00 for max(1, D) consecutive cycles. Any other command restarts that count.
- R8: A fault flag stays set until a cycle with the clear strobe high. A new fault in the same cycle as the strobe wins.
- R9: A leg captures the dead-time and minimum-width settings only in cycles when it is idle. A change applied while the leg is switching has no effect until the leg next passes through idle.
- R10: The three legs are independent. Commands, filtering, timing and faults of one leg do not affect the others.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| dead_cycles | input | 10 | Dead-time setting in clock cycles |
| min_width | input | 10 | Minimum accepted command width in clock cycles |
| fault_clr | input | 1 | Clear strobe for all fault flags |
| cmd_hi | input | 3 | Top-device command, one bit per leg |
| cmd_lo | input | 3 | Bottom-device command, one bit per leg |
| gate_hi | output | 3 | Top-device gate, one bit per leg |
| gate_lo | output | 3 | Bottom-device gate, one bit per leg |
| fault | output | 3 | Sticky illegal-command flag, one bit per leg |

## Verification
The bound checker watches several properties on every cycle:
- no leg ever drives both gates, and any gate turn-on follows a cycle with both gates low;
- fault flags hold until the strobe;
- a newly set fault comes with both gates low;
- the outputs are quiet after reset.

Other behaviour depends on the programmed settings and on the history of the command, and only the bench can show it by comparing against its cycle-level model:
- the exact length of each dead interval;
- rejection of pulses and notches shorter than the minimum width;
- the delayed release from the blocked state;
- settings taking effect only from idle;
- independence across legs.

// File: rtl/dtg_pkg.sv
`timescale 1ns/1ps
package dtg_pkg;
  // accepted command pair, encoded {top,bottom}
  localparam logic [1:0] CMD_IDLE = 2'b00;
  localparam logic [1:0] CMD_LO   = 2'b01;
  localparam logic [1:0] CMD_HI   = 2'b10;
  localparam logic [1:0] CMD_BAD  = 2'b11;

  typedef enum logic [2:0] {
    LEG_IDLE    = 3'd0,
    LEG_GAP_HI  = 3'd1,
    LEG_HI      = 3'd2,
    LEG_GAP_LO  = 3'd3,
    LEG_LO      = 3'd4,
    LEG_BLOCKED = 3'd5
  } leg_state_t;
endpackage

// File: rtl/dtg_cmd_filter.sv
`timescale 1ns/1ps
// Accepts a command pair only once it has held for min_w cycles.
module dtg_cmd_filter #(
  parameter int CW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    raw,
  input  logic [CW-1:0] min_w,
  output logic [1:0]    acc
);
  localparam logic [CW-1:0] RUN_MAX = '1;

  logic [1:0]    prev_q;
  logic [1:0]    acc_q;
  logic [CW-1:0] run_q;
  logic [CW-1:0] run_nx;

  // length of the current run of identical raw samples, this cycle included
  always_comb begin
    if (raw != prev_q)         run_nx = CW'(1);
    else if (run_q != RUN_MAX) run_nx = run_q + CW'(1);
    else                       run_nx = run_q;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      prev_q <= 2'b00;
      run_q  <= '0;
      acc_q  <= 2'b00;
    end else begin
      prev_q <= raw;
      run_q  <= run_nx;
      if (run_nx >= min_w) acc_q <= raw;
    end
  end

  assign acc = acc_q;
endmodule

// File: rtl/dtg_leg_fsm.sv
`timescale 1ns/1ps
// One converter leg: dead-time insertion, illegal-pair blocking, sticky fault.
module dtg_leg_fsm
  import dtg_pkg::*;
#(
  parameter int CW = 10
) (
  input  logic          clk,
  input  logic          rst,
  input  logic [1:0]    acc,
  input  logic [CW-1:0] dead_in,
  input  logic [CW-1:0] minw_in,
  input  logic          fault_clr,
  output logic [CW-1:0] minw_act,
  output logic          gate_hi,
  output logic          gate_lo,
  output logic          fault
);
  leg_state_t    state_q, state_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic [CW-1:0] dead_q, minw_q;
  logic          fault_q;
  logic          enter_blk;
  logic          gap_done;

  // the interval ends on the cycle in which cnt reaches dead-1 (a setting of 0 acts as 1)
  assign gap_done = ({1'b0, cnt_q} + (CW+1)'(1)) >= {1'b0, dead_q};

  always_comb begin
    state_d   = state_q;
    cnt_d     = cnt_q;
    enter_blk = 1'b0;
    if (state_q != LEG_BLOCKED && acc == CMD_BAD) begin
      state_d   = LEG_BLOCKED;
      cnt_d     = '0;
      enter_blk = 1'b1;
    end else begin
      unique case (state_q)
        LEG_IDLE: begin
          if (acc == CMD_HI)      begin state_d = LEG_GAP_HI; cnt_d = '0; end
          else if (acc == CMD_LO) begin state_d = LEG_GAP_LO; cnt_d = '0; end
        end
        LEG_GAP_HI: begin
          if (acc == CMD_HI) begin
            if (gap_done) begin state_d = LEG_HI; cnt_d = '0; end
            else cnt_d = cnt_q + CW'(1);
          end else if (acc == CMD_LO) begin state_d = LEG_GAP_LO; cnt_d = '0; end
          else begin state_d = LEG_IDLE; cnt_d = '0; end
        end
        LEG_GAP_LO: begin
          if (acc == CMD_LO) begin
            if (gap_done) begin state_d = LEG_LO; cnt_d = '0; end
            else cnt_d = cnt_q + CW'(1);
          end else if (acc == CMD_HI) begin state_d = LEG_GAP_HI; cnt_d = '0; end
          else begin state_d = LEG_IDLE; cnt_d = '0; end
        end
        LEG_HI: begin
          if (acc == CMD_LO)        begin state_d = LEG_GAP_LO; cnt_d = '0; end
          else if (acc == CMD_IDLE) begin state_d = LEG_IDLE;   cnt_d = '0; end
        end
        LEG_LO: begin
          if (acc == CMD_HI)        begin state_d = LEG_GAP_HI; cnt_d = '0; end
          else if (acc == CMD_IDLE) begin state_d = LEG_IDLE;   cnt_d = '0; end
        end
        LEG_BLOCKED: begin
          if (acc == CMD_IDLE) begin
            if (gap_done) begin state_d = LEG_IDLE; cnt_d = '0; end
            else cnt_d = cnt_q + CW'(1);
          end else cnt_d = '0;
        end
        default: begin state_d = LEG_IDLE; cnt_d = '0; end
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q <= LEG_IDLE;
      cnt_q   <= '0;
      dead_q  <= dead_in;
      minw_q  <= minw_in;
      fault_q <= 1'b0;
    end else begin
      state_q <= state_d;
      cnt_q   <= cnt_d;
      if (state_q == LEG_IDLE) begin
        dead_q <= dead_in;
        minw_q <= minw_in;
      end
      fault_q <= (fault_q & ~fault_clr) | enter_blk;
    end
  end

  assign gate_hi  = (state_q == LEG_HI);
  assign gate_lo  = (state_q == LEG_LO);
  assign fault    = fault_q;
  assign minw_act = minw_q;
endmodule

// File: rtl/deadtime_guard.sv
`timescale 1ns/1ps
module deadtime_guard #(
  parameter int LEGS = 3,
  parameter int CW   = 10
) (
  input  logic            clk,
  input  logic            rst,
  input  logic [CW-1:0]   dead_cycles,
  input  logic [CW-1:0]   min_width,
  input  logic            fault_clr,
  input  logic [LEGS-1:0] cmd_hi,
  input  logic [LEGS-1:0] cmd_lo,
  output logic [LEGS-1:0] gate_hi,
  output logic [LEGS-1:0] gate_lo,
  output logic [LEGS-1:0] fault
);
  for (genvar g = 0; g < LEGS; g++) begin : g_leg
    logic [1:0]    acc;
    logic [CW-1:0] minw_act;

    dtg_cmd_filter #(.CW(CW)) u_filt (
      .clk   (clk),
      .rst   (rst),
      .raw   ({cmd_hi[g], cmd_lo[g]}),
      .min_w (minw_act),
      .acc   (acc)
    );

    dtg_leg_fsm #(.CW(CW)) u_fsm (
      .clk       (clk),
      .rst       (rst),
      .acc       (acc),
      .dead_in   (dead_cycles),
      .minw_in   (min_width),
      .fault_clr (fault_clr),
      .minw_act  (minw_act),
      .gate_hi   (gate_hi[g]),
      .gate_lo   (gate_lo[g]),
      .fault     (fault[g])
    );
  end
endmodule

// File: rtl/dtg_checker.sv
`timescale 1ns/1ps
module dtg_checker #(
  parameter int LEGS = 3
) (
  input logic            clk,
  input logic            rst,
  input logic            fault_clr,
  input logic [LEGS-1:0] gate_hi,
  input logic [LEGS-1:0] gate_lo,
  input logic [LEGS-1:0] fault
);
  for (genvar g = 0; g < LEGS; g++) begin : g_chk
    AST_NO_SHOOT_THROUGH: assert property (@(posedge clk) disable iff (rst) !(gate_hi[g] && gate_lo[g])); // R2
    AST_HI_AFTER_GAP: assert property (@(posedge clk) disable iff (rst) $rose(gate_hi[g]) |-> $past(!gate_hi[g] && !gate_lo[g])); // R3
    AST_LO_AFTER_GAP: assert property (@(posedge clk) disable iff (rst) $rose(gate_lo[g]) |-> $past(!gate_hi[g] && !gate_lo[g])); // R3
    AST_FAULT_GATES_OFF: assert property (@(posedge clk) disable iff (rst) $rose(fault[g]) |-> (!gate_hi[g] && !gate_lo[g])); // R6
    AST_FAULT_STICKY: assert property (@(posedge clk) disable iff (rst) (fault[g] && !fault_clr) |=> fault[g]); // R8
  end
  AST_RESET_QUIET: assert property (@(posedge clk) rst |=> (gate_hi == '0 && gate_lo == '0 && fault == '0)); // R1
endmodule

bind deadtime_guard dtg_checker #(.LEGS(LEGS)) u_dtg_checker (
  .clk       (clk),
  .rst       (rst),
  .fault_clr (fault_clr),
  .gate_hi   (gate_hi),
  .gate_lo   (gate_lo),
  .fault     (fault)
);

// File: tb/tb_deadtime_guard.sv
`timescale 1ns/1ps
module tb_deadtime_guard;
  localparam int NL = 3;
  localparam int S_IDLE = 0, S_GH = 1, S_HI = 2, S_GL = 3, S_LO = 4, S_BLK = 5;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic [9:0]    dead_cycles = 10'd4;
  logic [9:0]    min_width = 10'd2;
  logic          fault_clr = 1'b0;
  logic [NL-1:0] cmd_hi = '0;
  logic [NL-1:0] cmd_lo = '0;
  logic [NL-1:0] gate_hi, gate_lo, fault;

  deadtime_guard dut (
    .clk(clk), .rst(rst), .dead_cycles(dead_cycles), .min_width(min_width),
    .fault_clr(fault_clr), .cmd_hi(cmd_hi), .cmd_lo(cmd_lo),
    .gate_hi(gate_hi), .gate_lo(gate_lo), .fault(fault)
  );

  always #2.5 clk = ~clk;

  int n_chk = 0;
  int n_fail = 0;
  bit mon_on = 0;
  bit done = 0;
  string cur_tag = "R4";

  int m_prev[NL], m_run[NL], m_acc[NL], m_st[NL], m_dc[NL], m_dt[NL], m_mw[NL];
  bit m_flt[NL];
  int off_run[NL], last_gap[NL];
  bit p_hi[NL], p_lo[NL];

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: got %0d expected %0d at %0t", tag, act, exp, $time);
    end
  endtask

  // behavioural reference, advanced on every rising edge
  always @(posedge clk) begin
    for (int l = 0; l < NL; l++) begin
      int r, rn, an, sn, dn, dte;
      bit ent, fin;
      if (rst) begin
        m_prev[l] = 0; m_run[l] = 0; m_acc[l] = 0; m_st[l] = S_IDLE; m_dc[l] = 0;
        m_dt[l] = int'(dead_cycles); m_mw[l] = int'(min_width); m_flt[l] = 0;
      end else begin
        r  = {cmd_hi[l], cmd_lo[l]};
        rn = (r != m_prev[l]) ? 1 : ((m_run[l] < 1023) ? m_run[l] + 1 : m_run[l]);
        an = (rn >= m_mw[l]) ? r : m_acc[l];
        dte = (m_dt[l] < 1) ? 1 : m_dt[l];
        fin = (m_dc[l] + 1 >= dte);
        sn = m_st[l]; dn = m_dc[l]; ent = 0;
        if (m_st[l] != S_BLK && m_acc[l] == 3) begin sn = S_BLK; dn = 0; ent = 1; end
        else if (m_st[l] == S_IDLE) begin
          if (m_acc[l] == 2) begin sn = S_GH; dn = 0; end
          else if (m_acc[l] == 1) begin sn = S_GL; dn = 0; end
        end else if (m_st[l] == S_GH || m_st[l] == S_GL) begin
          int want;
          want = (m_st[l] == S_GH) ? 2 : 1;
          if (m_acc[l] == want) begin
            if (fin) begin sn = (want == 2) ? S_HI : S_LO; dn = 0; end
            else dn = m_dc[l] + 1;
          end else if (m_acc[l] == 0) begin sn = S_IDLE; dn = 0; end
          else begin sn = (m_acc[l] == 2) ? S_GH : S_GL; dn = 0; end
        end else if (m_st[l] == S_HI || m_st[l] == S_LO) begin
          if (m_acc[l] == 0) begin sn = S_IDLE; dn = 0; end
          else if (m_acc[l] == 1 && m_st[l] == S_HI) begin sn = S_GL; dn = 0; end
          else if (m_acc[l] == 2 && m_st[l] == S_LO) begin sn = S_GH; dn = 0; end
        end else begin
          if (m_acc[l] == 0) begin
            if (fin) begin sn = S_IDLE; dn = 0; end else dn = m_dc[l] + 1;
          end else dn = 0;
        end
        if (m_st[l] == S_IDLE) begin m_dt[l] = int'(dead_cycles); m_mw[l] = int'(min_width); end
        m_flt[l] = (m_flt[l] && !fault_clr) || ent;
        m_prev[l] = r; m_run[l] = rn; m_acc[l] = an; m_st[l] = sn; m_dc[l] = dn;
      end
    end
  end

  // compare away from the active edge
  always @(negedge clk) begin
    if (mon_on) begin
      for (int l = 0; l < NL; l++) begin
        int dte;
        dte = (m_dt[l] < 1) ? 1 : m_dt[l];
        chk(gate_hi[l] == (m_st[l] == S_HI), cur_tag, int'(gate_hi[l]), int'(m_st[l] == S_HI));
        chk(gate_lo[l] == (m_st[l] == S_LO), cur_tag, int'(gate_lo[l]), int'(m_st[l] == S_LO));
        chk(fault[l] == m_flt[l], cur_tag, int'(fault[l]), int'(m_flt[l]));
        chk(!(gate_hi[l] && gate_lo[l]), "R2", int'({gate_hi[l], gate_lo[l]}), 0);
        if ((gate_hi[l] && !p_hi[l]) || (gate_lo[l] && !p_lo[l])) begin
          chk(off_run[l] >= dte, "R3", off_run[l], dte);
          last_gap[l] = off_run[l];
        end
        off_run[l] = (!gate_hi[l] && !gate_lo[l]) ? off_run[l] + 1 : 0;
        p_hi[l] = gate_hi[l];
        p_lo[l] = gate_lo[l];
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic setc(input int l, input int v);
    cmd_hi[l] = v[1];
    cmd_lo[l] = v[0];
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog: got %0d expected %0d", 0, 1);
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
      $finish;
    end
  end

  initial begin
    bit seen;
    logic [15:0] lfsr;
    for (int l = 0; l < NL; l++) begin off_run[l] = 0; last_gap[l] = 0; p_hi[l] = 0; p_lo[l] = 0; end
    cyc(3);
    chk(gate_hi == '0 && gate_lo == '0 && fault == '0, "R1", int'({gate_hi, gate_lo, fault}), 0);
    rst = 1'b0;
    cyc(1);
    chk(gate_hi == '0 && gate_lo == '0 && fault == '0, "R1", int'({gate_hi, gate_lo, fault}), 0);
    mon_on = 1;

    // basic switching, legs driven differently at once
    cur_tag = "R4";
    setc(0, 2); setc(1, 1);
    cyc(20);
    chk(gate_hi[0] == 1'b1, "R4", int'(gate_hi[0]), 1);
    chk(gate_lo[1] == 1'b1 && gate_hi[2] == 1'b0 && gate_lo[2] == 1'b0, "R10", int'({gate_lo[1], gate_hi[2], gate_lo[2]}), 4);
    setc(0, 1);
    cyc(20);
    chk(gate_lo[0] == 1'b1 && last_gap[0] == 4, "R4", last_gap[0], 4);
    setc(0, 0); setc(1, 0);
    cyc(10);
    chk(gate_hi == '0 && gate_lo == '0, "R4", int'({gate_hi, gate_lo}), 0);

    // settings captured only while idle
    cur_tag = "R9";
    setc(0, 2);
    cyc(15);
    dead_cycles = 10'd12;
    setc(0, 1);
    cyc(20);
    chk(last_gap[0] == 4, "R9", last_gap[0], 4);
    setc(0, 0);
    cyc(6);
    setc(0, 2);
    cyc(30);
    chk(gate_hi[0] == 1'b1 && last_gap[0] >= 12, "R9", last_gap[0], 12);
    setc(0, 0);
    cyc(8);

    // pulse filtering with width 5
    cur_tag = "R5";
    min_width = 10'd5; dead_cycles = 10'd3;
    cyc(3);
    setc(0, 2);
    cyc(4);
    setc(0, 0);
    for (int i = 0; i < 15; i++) begin
      cyc(1);
      chk(gate_hi[0] == 1'b0, "R5", int'(gate_hi[0]), 0);
    end
    setc(0, 2);
    cyc(5);
    setc(0, 0);
    seen = 0;
    for (int i = 0; i < 15; i++) begin
      cyc(1);
      if (gate_hi[0]) seen = 1;
    end
    chk(seen, "R5", int'(seen), 1);
    cyc(10);
    setc(0, 2);
    cyc(20);
    setc(0, 0); cyc(4); setc(0, 2);
    for (int i = 0; i < 12; i++) begin
      cyc(1);
      chk(gate_hi[0] == 1'b1, "R5", int'(gate_hi[0]), 1);
    end
    setc(0, 1); cyc(2); setc(0, 2);
    for (int i = 0; i < 12; i++) begin
      cyc(1);
      chk(gate_hi[0] == 1'b1 && gate_lo[0] == 1'b0, "R5", int'({gate_hi[0], gate_lo[0]}), 2);
    end
    setc(0, 0);
    cyc(10);

    // illegal pair, blocking, release and clearing
    cur_tag = "R6";
    setc(1, 1);
    cyc(15);
    setc(1, 3);
    cyc(8);
    chk(fault[1] == 1'b1 && gate_lo[1] == 1'b0 && gate_hi[1] == 1'b0, "R6", int'({fault[1], gate_hi[1], gate_lo[1]}), 4);
    chk(fault[0] == 1'b0 && fault[2] == 1'b0, "R10", int'({fault[0], fault[2]}), 0);
    cur_tag = "R7";
    setc(1, 0);
    cyc(3);
    setc(1, 1);
    cyc(2);
    setc(1, 0);
    cyc(3);
    setc(1, 2);
    cyc(4);
    chk(gate_hi[1] == 1'b0, "R7", int'(gate_hi[1]), 0);
    setc(1, 0);
    cyc(20);
    setc(1, 2);
    cyc(20);
    chk(gate_hi[1] == 1'b1, "R7", int'(gate_hi[1]), 1);
    cur_tag = "R8";
    chk(fault[1] == 1'b1, "R8", int'(fault[1]), 1);
    fault_clr = 1'b1; cyc(1); fault_clr = 1'b0;
    cyc(1);
    chk(fault[1] == 1'b0, "R8", int'(fault[1]), 0);
    setc(1, 0);
    cyc(10);

    // zero settings act as one
    cur_tag = "R3";
    dead_cycles = 10'd0; min_width = 10'd0;
    cyc(3);
    setc(2, 1);
    cyc(6);
    chk(gate_lo[2] == 1'b1 && last_gap[2] >= 1, "R3", last_gap[2], 1);
    setc(2, 0);
    cyc(4);

    // pseudo-random traffic on all legs
    cur_tag = "R10";
    dead_cycles = 10'd5; min_width = 10'd3;
    cyc(3);
    lfsr = 16'hACE1;
    for (int i = 0; i < 3000; i++) begin
      lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
      if (lfsr[3:0] == 4'h0) begin
        for (int l = 0; l < NL; l++) setc(l, (lfsr[9:8] == 2'b11 && l == i % NL) ? 3 : int'(lfsr[2*l +: 2] & 2'b10) >> (l % 2));
      end
      fault_clr = (lfsr[15:12] == 4'h7);
      cyc(1);
    end
    fault_clr = 1'b0;
    for (int l = 0; l < NL; l++) setc(l, 0);
    cyc(20);

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
    $finish;
  end
endmodule